// File: doc/BRIEF.md
# Duplex Channel Fault Arbiter

This block sits between two processing channels that compute the same actuator command by different means, a primary (index 0) and a standby (index 1), and the actuator they share. Each sample it receives both channels' input data, both commands with a per-channel validity bit, and an echo of the command the actuator holds. While nothing is wrong it passes the primary's command to the output.

Suspicion and confirmation are kept separate. A range check on the input data, the command validity bit, the actuator echo or a persistent disagreement between the two commands names a suspect channel. A diagnostic request is then issued for that channel. Only a failed or timed-out diagnostic marks the channel faulty. A confirmed fault on the active channel moves the output to the other channel, either at once (hot standby) or after a wake-up handshake (warm or cold standby). The cycle of the move is flagged as a lost sample. With both channels faulty the block drives a fixed safe command until reset.

Top module: `duplex_fault_arbiter`

## Requirements
- R1: Out of reset active_ch=0, fault_flag=0, diag_req=0, switch_pulse=0 and safe_state=0.
- R2: With no fault, out_cmd equals the active channel's command and out_valid equals smp_valid.
- R3: A channel is suspect when smp_valid is high and either its data lies outside cfg_lo..cfg_hi (both bounds inclusive and accepted) or its cmd_ok bit is 0. A suspect active channel is tested before a suspect standby, and a standby that already carries a fault flag is never tested. diag_req rises at the edge that samples the suspect input, and diag_ch gives the tested channel.
- R4: A command mismatch becomes a disagreement only on the cfg_persist-th consecutive valid mismatching sample. A valid matching sample clears the run, and a sample with smp_valid=0 neither extends nor clears it. A disagreement tests the active channel first, and tests the standby if the active one passes.
- R5: diag_done with diag_pass=1 ends the test with no flag. diag_done with diag_pass=0 sets the tested channel's sticky fault flag, and so does a test that receives no diag_done within DIAG_TO cycles.
- R6: In hot mode (cfg_mode=0), a confirmed fault on the active channel flips active_ch at the confirming edge. For that one cycle switch_pulse=1, out_lost=1 and out_valid=0.
- R7: In warm (cfg_mode=1) or cold (cfg_mode=2 or 3) mode, confirmation of the active channel's fault first enables the standby through ch_en. The output then switches on sby_ready, or after WARM_TO or COLD_TO cycles without it.
- R8: A confirmed fault on a standby channel that is not active sets its flag and leaves active_ch unchanged.
- R9: With both fault flags set, safe_state=1 and out_cmd=SAFE_CMD, no further test is requested, and this state holds until reset.
- R10: A valid sample whose act_fb differs from the last command delivered with out_valid=1 (SAFE_CMD after reset) makes the active channel suspect.
- R11: ch_en[i] is 0 for a faulty channel. Otherwise it is 1 for the active channel, for any channel in hot mode, and for the standby while a switchover waits for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Standby mode: 0 hot, 1 warm, 2/3 cold |
| cfg_lo | input | DATA_W | Lowest accepted input data value |
| cfg_hi | input | DATA_W | Highest accepted input data value |
| cfg_persist | input | PERSIST_W | Consecutive mismatches that make a disagreement |
| smp_valid | input | 1 | A new sample is present on both channels |
| pri_data | input | DATA_W | Primary channel input data |
| sec_data | input | DATA_W | Standby channel input data |
| pri_cmd | input | CMD_W | Primary channel command |
| sec_cmd | input | CMD_W | Standby channel command |
| pri_cmd_ok | input | 1 | Primary command validity |
| sec_cmd_ok | input | 1 | Standby command validity |
| act_fb | input | CMD_W | Command the actuator reports holding |
| diag_req | output | 1 | Diagnostic test request |
| diag_ch | output | 1 | Channel under diagnostic test |
| diag_done | input | 1 | Diagnostic finished |
| diag_pass | input | 1 | Diagnostic result, 1 = healthy |
| ch_en | output | 2 | Per-channel enable |
| sby_ready | input | 1 | Standby channel reports it is running |
| out_cmd | output | CMD_W | Selected actuator command |
| out_valid | output | 1 | out_cmd carries a fresh sample |
| out_lost | output | 1 | This sample is dropped by a switchover |
| active_ch | output | 1 | Channel driving out_cmd |
| fault_flag | output | 2 | Sticky confirmed-fault flags |
| switch_pulse | output | 1 | One-cycle pulse when the selection changes |
| safe_state | output | 1 | Both channels faulty, safe command driven |

## Verification
The properties assume that cfg_mode, cfg_lo, cfg_hi and cfg_persist change only while reset is held. The bench sets every configuration before it releases reset and never changes it afterwards. diag_done and sby_ready are taken to be single-cycle pulses given only while the block waits for them, and the bench drives them only in those cycles, from its responder tasks. act_fb is assumed to echo the last delivered command. The bench builds it from the outputs it has sampled, and corrupts it on purpose only in the feedback test.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
   typedef enum logic [1:0] {
      SB_HOT  = 2'd0,
      SB_WARM = 2'd1,
      SB_COLD = 2'd2
   } sb_mode_e;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_DIAG = 2'd1,
      ST_WAKE = 2'd2,
      ST_SAFE = 2'd3
   } arb_state_e;
endpackage

// File: rtl/dfa_accept.sv
module dfa_accept #(
   parameter int DATA_W = 8
) (
   input  logic [1:0][DATA_W-1:0] data,
   input  logic [DATA_W-1:0]      lo,
   input  logic [DATA_W-1:0]      hi,
   input  logic [1:0]             cmd_ok,
   input  logic                   smp_valid,
   output logic [1:0]             fail
);
   initial begin
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
   end

   for (genvar i = 0; i < 2; i++) begin : g_ch
      logic below, above;
      assign below   = data[i] < lo;
      assign above   = data[i] > hi;
      assign fail[i] = smp_valid && (below || above || !cmd_ok[i]);
   end
endmodule

// File: rtl/dfa_agree.sv
module dfa_agree #(
   parameter int CMD_W     = 8,
   parameter int PERSIST_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 smp_valid,
   input  logic [CMD_W-1:0]     cmd_a,
   input  logic [CMD_W-1:0]     cmd_b,
   input  logic [PERSIST_W-1:0] persist,
   output logic                 disagree
);
   localparam logic [PERSIST_W-1:0] CNT_MAX = {PERSIST_W{1'b1}};

   initial begin
      assert (PERSIST_W >= 1) else $error("PERSIST_W must be at least 1");
   end

   logic [PERSIST_W-1:0] run_len;
   logic                 mis;
   logic [PERSIST_W:0]   run_next;

   assign mis      = smp_valid && (cmd_a != cmd_b);
   assign run_next = {1'b0, run_len} + {{PERSIST_W{1'b0}}, 1'b1};
   assign disagree = run && mis && (run_next >= {1'b0, persist});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run_len <= '0;
      else if (!run)        run_len <= '0;
      else if (smp_valid) begin
         if (!mis)                  run_len <= '0;
         else if (run_len != CNT_MAX) run_len <= run_len + 1'b1;
      end
   end

   assert_disagree_differs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      disagree |-> (cmd_a != cmd_b && smp_valid));
endmodule

// File: rtl/dfa_ctrl.sv
module dfa_ctrl
   import dfa_pkg::*;
#(
   parameter int DIAG_TO = 16,
   parameter int WARM_TO = 8,
   parameter int COLD_TO = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       smp_valid,
   input  logic [1:0] acc_fail,
   input  logic       fb_bad,
   input  logic       disagree,
   input  logic       diag_done,
   input  logic       diag_pass,
   input  logic       sby_ready,
   output logic       run,
   output logic       active,
   output logic [1:0] fault,
   output logic       safe,
   output logic       diag_req,
   output logic       diag_ch,
   output logic       sw_pulse,
   output logic [1:0] ch_en
);
   localparam int TMAX0 = (DIAG_TO > WARM_TO) ? DIAG_TO : WARM_TO;
   localparam int TMAX  = (TMAX0 > COLD_TO) ? TMAX0 : COLD_TO;
   localparam int TW    = $clog2(TMAX + 1);
   localparam logic [TW-1:0] DIAG_LAST = TW'(DIAG_TO - 1);
   localparam logic [TW-1:0] WARM_LAST = TW'(WARM_TO - 1);
   localparam logic [TW-1:0] COLD_LAST = TW'(COLD_TO - 1);

   initial begin
      assert (DIAG_TO >= 2) else $error("DIAG_TO must be at least 2");
      assert (WARM_TO >= 2) else $error("WARM_TO must be at least 2");
      assert (COLD_TO >= 2) else $error("COLD_TO must be at least 2");
   end

   arb_state_e     state;
   logic           tst, dis_reason, other;
   logic [TW-1:0]  timer, wake_last;
   logic           is_hot;

   assign other     = ~active;
   assign is_hot    = (mode == SB_HOT);
   assign wake_last = (mode == SB_WARM) ? WARM_LAST : COLD_LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_RUN;
         active     <= 1'b0;
         fault      <= 2'b00;
         tst        <= 1'b0;
         dis_reason <= 1'b0;
         timer      <= '0;
         sw_pulse   <= 1'b0;
      end else begin
         sw_pulse <= 1'b0;
         case (state)
            ST_RUN: if (smp_valid) begin
               if (acc_fail[active] || fb_bad) begin
                  tst <= active; dis_reason <= 1'b0; timer <= '0; state <= ST_DIAG;
               end else if (acc_fail[other] && !fault[other]) begin
                  tst <= other; dis_reason <= 1'b0; timer <= '0; state <= ST_DIAG;
               end else if (disagree && !fault[other]) begin
                  tst <= active; dis_reason <= 1'b1; timer <= '0; state <= ST_DIAG;
               end
            end
            ST_DIAG: begin
               timer <= timer + 1'b1;
               if (diag_done && diag_pass) begin
                  if (dis_reason && tst == active) begin
                     tst <= other; dis_reason <= 1'b0; timer <= '0;
                  end else begin
                     state <= ST_RUN;
                  end
               end else if (diag_done || timer == DIAG_LAST) begin
                  fault[tst] <= 1'b1;
                  if (fault[~tst])         state <= ST_SAFE;
                  else if (tst != active)  state <= ST_RUN;
                  else if (is_hot) begin
                     active <= other; sw_pulse <= 1'b1; state <= ST_RUN;
                  end else begin
                     timer <= '0; state <= ST_WAKE;
                  end
               end
            end
            ST_WAKE: begin
               timer <= timer + 1'b1;
               if (sby_ready || timer == wake_last) begin
                  active <= other; sw_pulse <= 1'b1; state <= ST_RUN;
               end
            end
            default: state <= ST_SAFE;
         endcase
      end
   end

   assign run      = (state == ST_RUN);
   assign safe     = (state == ST_SAFE);
   assign diag_req = (state == ST_DIAG);
   assign diag_ch  = tst;

   for (genvar i = 0; i < 2; i++) begin : g_en
      assign ch_en[i] = !fault[i] &&
                        ((active == 1'(i)) || is_hot || (state == ST_WAKE));
   end

   assert_fault0_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault[0] |=> fault[0]);
   assert_fault1_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault[1] |=> fault[1]);
   assert_safe_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
      safe |=> safe);
   assert_safe_both_faulty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      safe |-> (fault == 2'b11));
   assert_switch_from_faulty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sw_pulse |-> (fault[other] && !fault[active]));
   assert_wake_not_hot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAKE) |-> !is_hot);
   assert_diag_from_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(diag_req) |-> $past(smp_valid));
endmodule

// File: rtl/duplex_fault_arbiter.sv
module duplex_fault_arbiter #(
   parameter int              CMD_W     = 8,
   parameter int              DATA_W    = 8,
   parameter int              PERSIST_W = 3,
   parameter int              DIAG_TO   = 16,
   parameter int              WARM_TO   = 8,
   parameter int              COLD_TO   = 32,
   parameter logic [CMD_W-1:0] SAFE_CMD = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cfg_mode,
   input  logic [DATA_W-1:0]    cfg_lo,
   input  logic [DATA_W-1:0]    cfg_hi,
   input  logic [PERSIST_W-1:0] cfg_persist,
   input  logic                 smp_valid,
   input  logic [DATA_W-1:0]    pri_data,
   input  logic [DATA_W-1:0]    sec_data,
   input  logic [CMD_W-1:0]     pri_cmd,
   input  logic [CMD_W-1:0]     sec_cmd,
   input  logic                 pri_cmd_ok,
   input  logic                 sec_cmd_ok,
   input  logic [CMD_W-1:0]     act_fb,
   output logic                 diag_req,
   output logic                 diag_ch,
   input  logic                 diag_done,
   input  logic                 diag_pass,
   output logic [1:0]           ch_en,
   input  logic                 sby_ready,
   output logic [CMD_W-1:0]     out_cmd,
   output logic                 out_valid,
   output logic                 out_lost,
   output logic                 active_ch,
   output logic [1:0]           fault_flag,
   output logic                 switch_pulse,
   output logic                 safe_state
);
   initial begin
      assert (CMD_W >= 1) else $error("CMD_W must be at least 1");
   end

   logic [1:0][DATA_W-1:0] data_v;
   logic [1:0][CMD_W-1:0]  cmd_v;
   logic [1:0]             acc_fail;
   logic                   disagree, run, fb_bad;
   logic [CMD_W-1:0]       last_cmd;

   assign data_v = {sec_data, pri_data};
   assign cmd_v  = {sec_cmd, pri_cmd};

   dfa_accept #(.DATA_W(DATA_W)) u_accept (
      .data(data_v), .lo(cfg_lo), .hi(cfg_hi),
      .cmd_ok({sec_cmd_ok, pri_cmd_ok}), .smp_valid(smp_valid), .fail(acc_fail)
   );

   dfa_agree #(.CMD_W(CMD_W), .PERSIST_W(PERSIST_W)) u_agree (
      .clk(clk), .rst_n(rst_n), .run(run), .smp_valid(smp_valid),
      .cmd_a(pri_cmd), .cmd_b(sec_cmd), .persist(cfg_persist), .disagree(disagree)
   );

   dfa_ctrl #(.DIAG_TO(DIAG_TO), .WARM_TO(WARM_TO), .COLD_TO(COLD_TO)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .smp_valid(smp_valid),
      .acc_fail(acc_fail), .fb_bad(fb_bad), .disagree(disagree),
      .diag_done(diag_done), .diag_pass(diag_pass), .sby_ready(sby_ready),
      .run(run), .active(active_ch), .fault(fault_flag), .safe(safe_state),
      .diag_req(diag_req), .diag_ch(diag_ch), .sw_pulse(switch_pulse), .ch_en(ch_en)
   );

   assign out_cmd   = safe_state ? SAFE_CMD : cmd_v[active_ch];
   assign out_valid = smp_valid && !switch_pulse;
   assign out_lost  = switch_pulse;
   assign fb_bad    = smp_valid && (act_fb != last_cmd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         last_cmd <= SAFE_CMD;
      else if (out_valid) last_cmd <= out_cmd;
   end

   assert_lost_not_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_lost |-> !out_valid);
   assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      switch_pulse |=> !switch_pulse);
endmodule

// File: tb/tb_duplex_fault_arbiter.sv
module tb_duplex_fault_arbiter;
   localparam int CW = 8, DW = 8, PW = 3;
   localparam int DIAG_TO = 6, WARM_TO = 4, COLD_TO = 5;
   localparam logic [7:0] SAFE = 8'hA5;
   localparam logic [7:0] LO = 8'd10, HI = 8'd100;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'd0;
   logic [DW-1:0] cfg_lo = LO, cfg_hi = HI;
   logic [PW-1:0] cfg_persist = 3'd2;
   logic smp_valid = 1'b0;
   logic [DW-1:0] pri_data = 8'd50, sec_data = 8'd50;
   logic [CW-1:0] pri_cmd = 8'h3C, sec_cmd = 8'h3C, act_fb = SAFE;
   logic pri_cmd_ok = 1'b1, sec_cmd_ok = 1'b1;
   logic diag_done = 1'b0, diag_pass = 1'b0, sby_ready = 1'b0;
   logic diag_req, diag_ch, out_valid, out_lost, active_ch, switch_pulse, safe_state;
   logic [1:0] ch_en, fault_flag;
   logic [CW-1:0] out_cmd;

   logic [CW-1:0] mirror = SAFE;
   int errors = 0, checks = 0, cycles = 0;

   always #5 clk = ~clk;

   duplex_fault_arbiter #(.CMD_W(CW), .DATA_W(DW), .PERSIST_W(PW), .DIAG_TO(DIAG_TO),
      .WARM_TO(WARM_TO), .COLD_TO(COLD_TO), .SAFE_CMD(SAFE)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
      .cfg_persist(cfg_persist), .smp_valid(smp_valid), .pri_data(pri_data),
      .sec_data(sec_data), .pri_cmd(pri_cmd), .sec_cmd(sec_cmd), .pri_cmd_ok(pri_cmd_ok),
      .sec_cmd_ok(sec_cmd_ok), .act_fb(act_fb), .diag_req(diag_req), .diag_ch(diag_ch),
      .diag_done(diag_done), .diag_pass(diag_pass), .ch_en(ch_en), .sby_ready(sby_ready),
      .out_cmd(out_cmd), .out_valid(out_valid), .out_lost(out_lost), .active_ch(active_ch),
      .fault_flag(fault_flag), .switch_pulse(switch_pulse), .safe_state(safe_state));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One clock: captures this cycle's delivered command for the actuator echo.
   task automatic tick(input bit keep_fb = 1'b0);
      logic v;
      logic [CW-1:0] c;
      #1;
      v = out_valid;
      c = out_cmd;
      @(posedge clk);
      @(negedge clk);
      if (v) mirror = c;
      if (!keep_fb) act_fb = mirror;
   endtask

   task automatic nominal();
      smp_valid = 1'b1; pri_data = 8'd50; sec_data = 8'd50;
      pri_cmd = 8'h3C; sec_cmd = 8'h3C; pri_cmd_ok = 1'b1; sec_cmd_ok = 1'b1;
      diag_done = 1'b0; diag_pass = 1'b0; sby_ready = 1'b0;
   endtask

   task automatic do_reset(input logic [1:0] mode);
      @(negedge clk);
      rst_n = 1'b0; cfg_mode = mode; nominal(); smp_valid = 1'b0;
      mirror = SAFE; act_fb = SAFE;
      tick(); tick();
      rst_n = 1'b1; smp_valid = 1'b1;
   endtask

   task automatic respond(input logic pass);
      diag_done = 1'b1; diag_pass = pass;
      tick();
      diag_done = 1'b0; diag_pass = 1'b0;
   endtask

   initial begin
      do_reset(2'd0);
      // R1 reset state
      chk("R1 active", active_ch, 0);
      chk("R1 faults", fault_flag, 0);
      chk("R1 diag_req", diag_req, 0);
      chk("R1 switch", switch_pulse, 0);
      chk("R1 safe", safe_state, 0);
      chk("R11 hot enables", ch_en, 2'b11);

      // R2 sweep of commands through the primary
      for (int c = 0; c < 256; c++) begin
         pri_cmd = 8'(c); sec_cmd = 8'(c);
         #1;
         chk("R2 out_cmd", out_cmd, c);
         chk("R2 out_valid", out_valid, 1);
         tick();
         chk("R2 no test", diag_req, 0);
      end
      smp_valid = 1'b0; #1;
      chk("R2 idle sample", out_valid, 0);
      tick();
      nominal(); tick();

      // R3 acceptance boundaries on both channels, R5 passing diagnostic
      for (int ch = 0; ch < 2; ch++)
         for (int k = 0; k < 8; k++)
            for (int ok = 0; ok < 2; ok++) begin
               int d;
               bit bad;
               d = (k < 4) ? (int'(LO) - 2 + k) : (int'(HI) - 1 + (k - 4));
               bad = (d < int'(LO)) || (d > int'(HI)) || (ok == 0);
               if (ch == 0) begin pri_data = 8'(d); pri_cmd_ok = 1'(ok); end
               else         begin sec_data = 8'(d); sec_cmd_ok = 1'(ok); end
               tick();
               nominal();
               chk("R3 suspect raised", diag_req, int'(bad));
               if (bad) begin
                  chk("R3 tested channel", diag_ch, ch);
                  respond(1'b1);
                  chk("R5 pass clears request", diag_req, 0);
                  chk("R5 pass leaves flags", fault_flag, 0);
               end
            end

      // R4 persistence sweep
      for (int p = 1; p < 5; p++) begin
         do_reset(2'd0);
         cfg_persist = 3'(p);
         do_reset(2'd0);
         sec_cmd = 8'h3D;
         for (int s = 1; s < p; s++) begin
            tick();
            chk("R4 below persistence", diag_req, 0);
         end
         tick();
         sec_cmd = 8'h3C;
         chk("R4 disagreement", diag_req, 1);
         chk("R4 active tested first", diag_ch, 0);
         respond(1'b1);
         chk("R4 standby tested next", diag_ch, 1);
         chk("R4 still testing", diag_req, 1);
         respond(1'b1);
         chk("R4 both passed", diag_req, 0);
      end
      cfg_persist = 3'd3;
      do_reset(2'd0);
      sec_cmd = 8'h3D; tick(); tick();
      sec_cmd = 8'h3C; tick();
      sec_cmd = 8'h3D; tick(); tick();
      chk("R4 match clears run", diag_req, 0);
      sec_cmd = 8'h3C; tick();
      sec_cmd = 8'h3D; tick(); tick();
      smp_valid = 1'b0; tick();
      chk("R4 idle holds run", diag_req, 0);
      smp_valid = 1'b1; tick();
      chk("R4 idle did not clear", diag_req, 1);
      sec_cmd = 8'h3C;
      respond(1'b1); respond(1'b1);

      // R10 actuator echo mismatch
      do_reset(2'd0);
      tick();
      act_fb = mirror ^ 8'h01;
      tick(1'b1);
      act_fb = mirror;
      chk("R10 echo suspect", diag_req, 1);
      chk("R10 echo tests active", diag_ch, 0);
      respond(1'b1);
      chk("R10 echo cleared", diag_req, 0);

      // R5 timeout on standby, R8 standby fault keeps selection
      do_reset(2'd0);
      sec_cmd_ok = 1'b0; tick(); sec_cmd_ok = 1'b1;
      for (int t = 1; t < DIAG_TO; t++) tick();
      chk("R5 waiting before timeout", diag_req, 1);
      tick();
      chk("R5 timeout flags standby", fault_flag, 2'b10);
      chk("R8 active unchanged", active_ch, 0);
      chk("R8 no switch", switch_pulse, 0);
      chk("R11 faulty disabled", ch_en, 2'b01);
      // R9 second fault
      pri_data = 8'd200; tick(); pri_data = 8'd50;
      chk("R9 active tested", diag_ch, 0);
      respond(1'b0);
      chk("R9 safe", safe_state, 1);
      chk("R9 safe cmd", out_cmd, SAFE);
      chk("R9 both flags", fault_flag, 2'b11);
      chk("R11 all disabled", ch_en, 2'b00);
      pri_cmd_ok = 1'b0; sec_cmd_ok = 1'b0;
      for (int t = 0; t < 4; t++) tick();
      chk("R9 no further test", diag_req, 0);
      chk("R9 held", safe_state, 1);
      nominal();

      // R6 hot switchover
      do_reset(2'd0);
      pri_data = 8'd5; tick(); pri_data = 8'd50;
      respond(1'b0);
      chk("R6 active flips", active_ch, 1);
      chk("R6 pulse", switch_pulse, 1);
      chk("R6 lost", out_lost, 1);
      chk("R6 not valid", out_valid, 0);
      sec_cmd = 8'h77; tick();
      chk("R6 pulse ends", switch_pulse, 0);
      chk("R6 follows standby", out_cmd, 8'h77);
      chk("R6 valid again", out_valid, 1);

      // R7 warm with ready
      do_reset(2'd1);
      chk("R11 warm enables", ch_en, 2'b01);
      pri_cmd_ok = 1'b0; tick(); pri_cmd_ok = 1'b1;
      respond(1'b0);
      chk("R7 waiting", active_ch, 0);
      chk("R11 wake enables standby", ch_en, 2'b10);
      tick();
      chk("R7 still waiting", active_ch, 0);
      sby_ready = 1'b1; tick(); sby_ready = 1'b0;
      chk("R7 ready switches", active_ch, 1);
      chk("R7 pulse", switch_pulse, 1);

      // R7 cold timeout
      do_reset(2'd2);
      pri_data = 8'd101; tick(); pri_data = 8'd50;
      respond(1'b0);
      for (int t = 1; t < COLD_TO; t++) tick();
      chk("R7 before cold timeout", active_ch, 0);
      tick();
      chk("R7 cold timeout switches", active_ch, 1);
      chk("R7 cold lost", out_lost, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule